// File: doc/BRIEF.md
# Pointer Load/Store Address Generator

This block turns one issued load/store request into a memory address, one access strobe and a pointer update. A single unit serves three 16-bit pointers that a register file supplies (selected as X, Y or Z). It supports five data addressing forms: plain pointer, pointer then increment, decrement then pointer, pointer plus a small unsigned displacement (Y and Z only), and a 16-bit direct address. A program-memory read path addresses through Z. Its extended form puts a page byte above Z to make a 24-bit address, and its incrementing form advances that 24-bit value as a whole.

The issuing stage raises `issue` for one cycle with the request fields and the current pointer values. The block captures everything on that edge. It then holds `busy` high for the extra cycles of the operation so the issuer stalls, and presents a stable address. It also reports the pointer (and page) write-back values for the register file and the destination register index for loads.

Top module: `ldst_agu`

## Requirements
- R1: While and directly after reset, `busy`, `data_rd`, `data_wr`, `prog_rd`, `ptr_wb_en` and `page_wb_en` are low.
- R2: The operation code is 0 plain, 1 post-increment, 2 pre-decrement, 3 displacement, 4 direct, 5 program read, 6 program read with increment, 7 reserved. The pointer select is 0 X, 1 Y, 2 Z, 3 none. A plain operation addresses the selected pointer (upper 8 address bits zero) and requests no write-back.
- R3: Post-increment addresses the current pointer and writes back pointer+1 modulo 2^16 to the selected pointer.
- R4: Pre-decrement addresses pointer-1 modulo 2^16 and writes that same value back.
- R5: Displacement addresses pointer + `disp` (unsigned, 0..63) modulo 2^16 without write-back, and only with Y or Z. A displacement with X, any data operation with select 3, and code 7 are dropped: no busy, no strobe.
- R6: Direct addresses `direct_addr` with no write-back.
- R7: A data operation takes 2 clocks. `busy` is high for exactly the one cycle after the issue edge. In that cycle `data_wr` pulses if `is_store` is 1, and `data_rd` pulses otherwise.
- R8: A program read takes 3 clocks. `busy` is high for the two cycles after the issue edge, `prog_rd` pulses in the first of them, Z is always used, and `is_store` is ignored.
- R9: With `ext_en` set, the program address is {`page`, Z}, and the incrementing form writes back ({page,Z}+1) modulo 2^24 as Z (`ptr_wb_val`) and page (`page_wb_en`, `page_wb_val`). Without it, the address is {8'h00, Z}, Z wraps modulo 2^16 and the page is not written.
- R10: `dst_idx` is 0 for a program read with `implicit_dst` set, and `rd_idx` otherwise.
- R11: `issue` while `busy` is high is ignored: the address, the busy length and the write-back of the running operation are unchanged.
- R12: `mem_addr` is stable for all busy cycles, and `ptr_wb_en` (with `ptr_wb_sel`) is high only in the last busy cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue | input | 1 | Request valid for one cycle |
| op | input | 3 | Operation code (R2) |
| ptr_sel | input | 2 | Pointer select (R2) |
| is_store | input | 1 | 1 store, 0 load (data operations) |
| ext_en | input | 1 | Use page byte above Z for program reads |
| implicit_dst | input | 1 | Operand-less program read, load into register 0 |
| rd_idx | input | 5 | Load destination register index |
| disp | input | 6 | Unsigned displacement |
| direct_addr | input | 16 | Direct data address |
| x_ptr | input | 16 | Current X pointer value |
| y_ptr | input | 16 | Current Y pointer value |
| z_ptr | input | 16 | Current Z pointer value |
| page | input | 8 | Current page byte |
| busy | output | 1 | Operation in flight, issuer stalls |
| mem_addr | output | 24 | Memory address |
| data_rd | output | 1 | Data memory read strobe |
| data_wr | output | 1 | Data memory write strobe |
| prog_rd | output | 1 | Program memory read strobe |
| dst_idx | output | 5 | Destination register for the load |
| ptr_wb_en | output | 1 | Pointer write-back enable |
| ptr_wb_sel | output | 2 | Pointer being written back |
| ptr_wb_val | output | 16 | Pointer write-back value |
| page_wb_en | output | 1 | Page byte write-back enable |
| page_wb_val | output | 8 | Page byte write-back value |

## Verification
The address, strobe, destination index and busy flag are due in the first cycle after the issue edge. A data operation's write-back is due in that same cycle, and `busy` must be low in the next one. A program read has its strobe in the first busy cycle, its write-back in the second, and `busy` low in the third. The bench drives at falling edges and samples each result at the falling edge of exactly that cycle, comparing against values its own model computed from the inputs present at issue. It changes the pointer inputs and pulses `issue` mid-operation to show that captured state is kept.

// File: rtl/ldst_agu_pkg.sv
package ldst_agu_pkg;

   typedef enum logic [2:0] {
      OP_IND      = 3'd0,
      OP_POST_INC = 3'd1,
      OP_PRE_DEC  = 3'd2,
      OP_DISP     = 3'd3,
      OP_DIRECT   = 3'd4,
      OP_PROG     = 3'd5,
      OP_PROG_INC = 3'd6,
      OP_RSVD     = 3'd7
   } agu_op_e;

   typedef enum logic [1:0] {
      PSEL_X    = 2'd0,
      PSEL_Y    = 2'd1,
      PSEL_Z    = 2'd2,
      PSEL_NONE = 2'd3
   } ptr_sel_e;

   typedef enum logic [1:0] {
      ACC_NONE = 2'd0,
      ACC_DRD  = 2'd1,
      ACC_DWR  = 2'd2,
      ACC_PRD  = 2'd3
   } acc_e;

endpackage

// File: rtl/ldst_agu_calc.sv
module ldst_agu_calc
   import ldst_agu_pkg::*;
#(
   parameter int PTR_W    = 16,
   parameter int PAGE_W   = 8,
   parameter int DISP_W   = 6,
   parameter bit HAS_PAGE = 1'b1,
   localparam int ADDR_W  = PTR_W + PAGE_W
) (
   input  agu_op_e            op,
   input  ptr_sel_e           sel,
   input  logic               is_store,
   input  logic               ext_en,
   input  logic [DISP_W-1:0]  disp,
   input  logic [PTR_W-1:0]   direct_addr,
   input  logic [PTR_W-1:0]   x_ptr,
   input  logic [PTR_W-1:0]   y_ptr,
   input  logic [PTR_W-1:0]   z_ptr,
   input  logic [PAGE_W-1:0]  page,
   output logic               legal,
   output acc_e               acc,
   output logic [ADDR_W-1:0]  addr,
   output logic               wb_en,
   output ptr_sel_e           wb_sel,
   output logic [PTR_W-1:0]   wb_val,
   output logic               page_wb_en,
   output logic [PAGE_W-1:0]  page_wb_val
);

   localparam logic [PTR_W-1:0]  ONE_P = PTR_W'(1);
   localparam logic [ADDR_W-1:0] ONE_A = ADDR_W'(1);

   logic [PAGE_W-1:0] eff_page;
   logic              page_used;
   logic [PTR_W-1:0]  ptr;
   logic [PTR_W-1:0]  ptr_inc;
   logic [PTR_W-1:0]  ptr_dec;
   logic [PTR_W-1:0]  ptr_disp;
   logic [ADDR_W-1:0] lin;
   logic [ADDR_W-1:0] lin_inc;
   acc_e              data_acc;

   generate
      if (HAS_PAGE) begin : g_page
         assign eff_page  = ext_en ? page : '0;
         assign page_used = ext_en;
      end else begin : g_nopage
         logic unused_page;
         assign unused_page = ext_en ^ (^page);
         assign eff_page    = '0;
         assign page_used   = 1'b0;
      end
   endgenerate

   always_comb begin
      unique case (sel)
         PSEL_X:  ptr = x_ptr;
         PSEL_Y:  ptr = y_ptr;
         PSEL_Z:  ptr = z_ptr;
         default: ptr = '0;
      endcase
   end

   assign ptr_inc  = ptr + ONE_P;
   assign ptr_dec  = ptr - ONE_P;
   assign ptr_disp = ptr + {{(PTR_W-DISP_W){1'b0}}, disp};
   assign lin      = {eff_page, z_ptr};
   assign lin_inc  = lin + ONE_A;
   assign data_acc = is_store ? ACC_DWR : ACC_DRD;

   always_comb begin
      legal       = 1'b0;
      acc         = ACC_NONE;
      addr        = '0;
      wb_en       = 1'b0;
      wb_sel      = sel;
      wb_val      = '0;
      page_wb_en  = 1'b0;
      page_wb_val = '0;
      unique case (op)
         OP_IND: begin
            legal = (sel != PSEL_NONE);
            acc   = data_acc;
            addr  = {{PAGE_W{1'b0}}, ptr};
         end
         OP_POST_INC: begin
            legal  = (sel != PSEL_NONE);
            acc    = data_acc;
            addr   = {{PAGE_W{1'b0}}, ptr};
            wb_en  = 1'b1;
            wb_val = ptr_inc;
         end
         OP_PRE_DEC: begin
            legal  = (sel != PSEL_NONE);
            acc    = data_acc;
            addr   = {{PAGE_W{1'b0}}, ptr_dec};
            wb_en  = 1'b1;
            wb_val = ptr_dec;
         end
         OP_DISP: begin
            legal = (sel == PSEL_Y) || (sel == PSEL_Z);
            acc   = data_acc;
            addr  = {{PAGE_W{1'b0}}, ptr_disp};
         end
         OP_DIRECT: begin
            legal = 1'b1;
            acc   = data_acc;
            addr  = {{PAGE_W{1'b0}}, direct_addr};
         end
         OP_PROG, OP_PROG_INC: begin
            legal  = 1'b1;
            acc    = ACC_PRD;
            addr   = lin;
            wb_sel = PSEL_Z;
            if (op == OP_PROG_INC) begin
               wb_en       = 1'b1;
               wb_val      = lin_inc[PTR_W-1:0];
               page_wb_en  = page_used;
               page_wb_val = lin_inc[ADDR_W-1:PTR_W];
            end
         end
         default: legal = 1'b0;
      endcase
   end

endmodule

// File: rtl/ldst_agu_seq.sv
module ldst_agu_seq #(
   parameter int DATA_LAT = 2,
   parameter int PROG_LAT = 3,
   localparam int CNT_W   = $clog2(PROG_LAT + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic issue,
   input  logic legal,
   input  logic is_prog,
   output logic accept,
   output logic busy,
   output logic first,
   output logic last
);

   localparam logic [CNT_W-1:0] DATA_EXTRA = CNT_W'(DATA_LAT - 1);
   localparam logic [CNT_W-1:0] PROG_EXTRA = CNT_W'(PROG_LAT - 1);
   localparam logic [CNT_W-1:0] ONE_C      = CNT_W'(1);

   logic [CNT_W-1:0] remain;

   assign busy   = (remain != '0);
   assign last   = (remain == ONE_C);
   assign accept = issue && legal && !busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         remain <= '0;
         first  <= 1'b0;
      end else if (accept) begin
         remain <= is_prog ? PROG_EXTRA : DATA_EXTRA;
         first  <= 1'b1;
      end else begin
         if (busy) remain <= remain - ONE_C;
         first <= 1'b0;
      end
   end

endmodule

// File: rtl/ldst_agu.sv
module ldst_agu
   import ldst_agu_pkg::*;
#(
   parameter int PTR_W    = 16,
   parameter int PAGE_W   = 8,
   parameter int DISP_W   = 6,
   parameter int REG_W    = 5,
   parameter int DATA_LAT = 2,
   parameter int PROG_LAT = 3,
   parameter bit HAS_PAGE = 1'b1,
   localparam int ADDR_W  = PTR_W + PAGE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue,
   input  logic [2:0]        op,
   input  logic [1:0]        ptr_sel,
   input  logic              is_store,
   input  logic              ext_en,
   input  logic              implicit_dst,
   input  logic [REG_W-1:0]  rd_idx,
   input  logic [DISP_W-1:0] disp,
   input  logic [PTR_W-1:0]  direct_addr,
   input  logic [PTR_W-1:0]  x_ptr,
   input  logic [PTR_W-1:0]  y_ptr,
   input  logic [PTR_W-1:0]  z_ptr,
   input  logic [PAGE_W-1:0] page,
   output logic              busy,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              data_rd,
   output logic              data_wr,
   output logic              prog_rd,
   output logic [REG_W-1:0]  dst_idx,
   output logic              ptr_wb_en,
   output logic [1:0]        ptr_wb_sel,
   output logic [PTR_W-1:0]  ptr_wb_val,
   output logic              page_wb_en,
   output logic [PAGE_W-1:0] page_wb_val
);

   generate
      if (DATA_LAT < 2) begin : g_bad_data_lat
         initial $fatal(1, "ldst_agu: DATA_LAT must be at least 2");
      end
      if (PROG_LAT <= DATA_LAT) begin : g_bad_prog_lat
         initial $fatal(1, "ldst_agu: PROG_LAT must exceed DATA_LAT");
      end
      if (DISP_W >= PTR_W) begin : g_bad_disp
         initial $fatal(1, "ldst_agu: DISP_W must be narrower than PTR_W");
      end
   endgenerate

   agu_op_e  op_e;
   ptr_sel_e sel_e;
   assign op_e  = agu_op_e'(op);
   assign sel_e = ptr_sel_e'(ptr_sel);

   logic              c_legal;
   acc_e              c_acc;
   logic [ADDR_W-1:0] c_addr;
   logic              c_wb_en;
   ptr_sel_e          c_wb_sel;
   logic [PTR_W-1:0]  c_wb_val;
   logic              c_pg_en;
   logic [PAGE_W-1:0] c_pg_val;

   ldst_agu_calc #(
      .PTR_W(PTR_W), .PAGE_W(PAGE_W), .DISP_W(DISP_W), .HAS_PAGE(HAS_PAGE)
   ) calc_i (
      .op(op_e), .sel(sel_e), .is_store(is_store), .ext_en(ext_en),
      .disp(disp), .direct_addr(direct_addr),
      .x_ptr(x_ptr), .y_ptr(y_ptr), .z_ptr(z_ptr), .page(page),
      .legal(c_legal), .acc(c_acc), .addr(c_addr),
      .wb_en(c_wb_en), .wb_sel(c_wb_sel), .wb_val(c_wb_val),
      .page_wb_en(c_pg_en), .page_wb_val(c_pg_val)
   );

   logic accept, first, last;

   ldst_agu_seq #(
      .DATA_LAT(DATA_LAT), .PROG_LAT(PROG_LAT)
   ) seq_i (
      .clk(clk), .rst_n(rst_n), .issue(issue), .legal(c_legal),
      .is_prog(c_acc == ACC_PRD),
      .accept(accept), .busy(busy), .first(first), .last(last)
   );

   logic              is_prog_op;
   acc_e              acc_q;
   logic              wb_en_q;
   ptr_sel_e          wb_sel_q;
   logic              pg_en_q;
   assign is_prog_op = (op_e == OP_PROG) || (op_e == OP_PROG_INC);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mem_addr    <= '0;
         acc_q       <= ACC_NONE;
         wb_en_q     <= 1'b0;
         wb_sel_q    <= PSEL_X;
         ptr_wb_val  <= '0;
         pg_en_q     <= 1'b0;
         page_wb_val <= '0;
         dst_idx     <= '0;
      end else if (accept) begin
         mem_addr    <= c_addr;
         acc_q       <= c_acc;
         wb_en_q     <= c_wb_en;
         wb_sel_q    <= c_wb_sel;
         ptr_wb_val  <= c_wb_val;
         pg_en_q     <= c_pg_en;
         page_wb_val <= c_pg_val;
         dst_idx     <= (is_prog_op && implicit_dst) ? '0 : rd_idx;
      end
   end

   assign data_rd    = first && (acc_q == ACC_DRD);
   assign data_wr    = first && (acc_q == ACC_DWR);
   assign prog_rd    = first && (acc_q == ACC_PRD);
   assign ptr_wb_en  = last && wb_en_q;
   assign page_wb_en = last && pg_en_q;
   assign ptr_wb_sel = wb_sel_q;

endmodule

// File: rtl/ldst_agu_chk.sv
module ldst_agu_chk #(
   parameter int DATA_LAT = 2,
   parameter int PROG_LAT = 3,
   parameter int ADDR_W   = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              data_rd,
   input logic              data_wr,
   input logic              prog_rd,
   input logic              ptr_wb_en,
   input logic              page_wb_en,
   input logic [ADDR_W-1:0] mem_addr
);

   localparam logic [7:0] DATA_RUN = 8'(DATA_LAT - 1);
   localparam logic [7:0] PROG_RUN = 8'(PROG_LAT - 1);

   logic [7:0] run;
   logic       saw_prog;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run      <= '0;
         saw_prog <= 1'b0;
      end else begin
         run      <= busy ? run + 8'd1 : 8'd0;
         saw_prog <= busy && (saw_prog || prog_rd);
      end
   end

   assert_one_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({data_rd, data_wr, prog_rd}));

   assert_strobe_needs_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (data_rd || data_wr || prog_rd) |-> busy);

   assert_strobe_at_start_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (data_rd || data_wr || prog_rd));

   assert_addr_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(mem_addr));

   assert_wb_in_last_R12: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_wb_en |=> !busy);

   assert_page_with_ptr_R9: assert property (@(posedge clk) disable iff (!rst_n)
      page_wb_en |-> ptr_wb_en);

   assert_data_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy) && !saw_prog) |-> (run == DATA_RUN));

   assert_prog_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy) && saw_prog) |-> (run == PROG_RUN));

endmodule

bind ldst_agu ldst_agu_chk #(
   .DATA_LAT(DATA_LAT), .PROG_LAT(PROG_LAT), .ADDR_W(ADDR_W)
) chk_i (
   .clk(clk), .rst_n(rst_n), .busy(busy), .data_rd(data_rd),
   .data_wr(data_wr), .prog_rd(prog_rd), .ptr_wb_en(ptr_wb_en),
   .page_wb_en(page_wb_en), .mem_addr(mem_addr)
);

// File: tb/ldst_agu_tb.sv
`timescale 1ns/1ps
module ldst_agu_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        issue = 1'b0;
   logic [2:0]  op = '0;
   logic [1:0]  ptr_sel = '0;
   logic        is_store = 1'b0, ext_en = 1'b0, implicit_dst = 1'b0;
   logic [4:0]  rd_idx = '0;
   logic [5:0]  disp = '0;
   logic [15:0] direct_addr = '0, x_ptr = '0, y_ptr = '0, z_ptr = '0;
   logic [7:0]  page = '0;
   logic        busy, data_rd, data_wr, prog_rd, ptr_wb_en, page_wb_en;
   logic [23:0] mem_addr;
   logic [4:0]  dst_idx;
   logic [1:0]  ptr_wb_sel;
   logic [15:0] ptr_wb_val;
   logic [7:0]  page_wb_val;

   always #4 clk = ~clk;

   ldst_agu dut_i (
      .clk(clk), .rst_n(rst_n), .issue(issue), .op(op), .ptr_sel(ptr_sel),
      .is_store(is_store), .ext_en(ext_en), .implicit_dst(implicit_dst),
      .rd_idx(rd_idx), .disp(disp), .direct_addr(direct_addr),
      .x_ptr(x_ptr), .y_ptr(y_ptr), .z_ptr(z_ptr), .page(page),
      .busy(busy), .mem_addr(mem_addr), .data_rd(data_rd), .data_wr(data_wr),
      .prog_rd(prog_rd), .dst_idx(dst_idx), .ptr_wb_en(ptr_wb_en),
      .ptr_wb_sel(ptr_wb_sel), .ptr_wb_val(ptr_wb_val),
      .page_wb_en(page_wb_en), .page_wb_val(page_wb_val)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   // access kinds: 0 none, 1 data read, 2 data write, 3 program read
   task automatic model(output bit legal, output int kind, output logic [23:0] a,
                        output bit wbe, output logic [1:0] wsel,
                        output logic [15:0] wval, output bit pge,
                        output logic [7:0] pval, output logic [4:0] dst);
      logic [15:0] p;
      logic [23:0] lin;
      p = (ptr_sel == 2'd0) ? x_ptr : (ptr_sel == 2'd1) ? y_ptr : z_ptr;
      legal = 1'b0; kind = 0; a = '0; wbe = 1'b0; wsel = ptr_sel;
      wval = '0; pge = 1'b0; pval = '0; dst = rd_idx;
      if (op <= 3'd4) kind = is_store ? 2 : 1;
      case (op)
         3'd0: begin legal = (ptr_sel != 2'd3); a = {8'h00, p}; end
         3'd1: begin legal = (ptr_sel != 2'd3); a = {8'h00, p};
                     wbe = 1'b1; wval = p + 16'd1; end
         3'd2: begin legal = (ptr_sel != 2'd3); a = {8'h00, p - 16'd1};
                     wbe = 1'b1; wval = p - 16'd1; end
         3'd3: begin legal = (ptr_sel == 2'd1) || (ptr_sel == 2'd2);
                     a = {8'h00, p + {10'd0, disp}}; end
         3'd4: begin legal = 1'b1; a = {8'h00, direct_addr}; end
         3'd5, 3'd6: begin
            legal = 1'b1; kind = 3; wsel = 2'd2;
            if (implicit_dst) dst = 5'd0;
            lin = ext_en ? {page, z_ptr} : {8'h00, z_ptr};
            a = lin;
            if (op == 3'd6) begin
               wbe = 1'b1;
               if (ext_en) begin
                  lin = lin + 24'd1;
                  wval = lin[15:0]; pge = 1'b1; pval = lin[23:16];
               end else begin
                  wval = z_ptr + 16'd1;
               end
            end
         end
         default: legal = 1'b0;
      endcase
      if (!legal) kind = 0;
   endtask

   task automatic run_op(input string req, input bit poke);
      bit legal, wbe, pge;
      int kind;
      logic [23:0] ea;
      logic [1:0]  ws;
      logic [15:0] wv;
      logic [7:0]  pv;
      logic [4:0]  ed;
      model(legal, kind, ea, wbe, ws, wv, pge, pv, ed);
      issue = 1'b1;
      @(negedge clk);
      issue = 1'b0;
      if (!legal) begin
         chk(!busy && !data_rd && !data_wr && !prog_rd, "R5", {req, " dropped op idle"},
             {busy, data_rd, data_wr, prog_rd}, 0);
         return;
      end
      // first busy cycle
      chk(busy == 1'b1, "R7", {req, " busy after issue"}, busy, 1);
      chk({data_rd, data_wr, prog_rd} == {kind == 1, kind == 2, kind == 3},
          kind == 3 ? "R8" : "R7", {req, " strobe"},
          {data_rd, data_wr, prog_rd}, {kind == 1, kind == 2, kind == 3});
      chk(mem_addr == ea, "R2", {req, " address"}, mem_addr, ea);
      chk(dst_idx == ed, "R10", {req, " destination"}, dst_idx, ed);
      // disturb inputs: captured state must hold
      x_ptr = 16'($urandom); y_ptr = 16'($urandom); z_ptr = 16'($urandom);
      page = 8'($urandom);
      if (poke) begin
         issue = 1'b1; op = 3'd4; direct_addr = ~ea[15:0];
      end
      if (kind != 3) begin
         chk(ptr_wb_en == wbe, "R3", {req, " wb enable"}, ptr_wb_en, wbe);
         if (wbe) begin
            chk(ptr_wb_val == wv, "R4", {req, " wb value"}, ptr_wb_val, wv);
            chk(ptr_wb_sel == ws, "R3", {req, " wb select"}, ptr_wb_sel, ws);
         end
         @(negedge clk);
         issue = 1'b0;
         chk(busy == 1'b0, poke ? "R11" : "R7", {req, " busy ends"}, busy, 0);
      end else begin
         chk(ptr_wb_en == 1'b0, "R12", {req, " no early wb"}, ptr_wb_en, 0);
         @(negedge clk);
         issue = 1'b0;
         chk(busy == 1'b1 && !prog_rd, "R8", {req, " second busy cycle"},
             {busy, prog_rd}, 2'b10);
         chk(mem_addr == ea, poke ? "R11" : "R12", {req, " address held"}, mem_addr, ea);
         chk(ptr_wb_en == wbe, "R12", {req, " wb in last cycle"}, ptr_wb_en, wbe);
         chk(page_wb_en == pge, "R9", {req, " page wb enable"}, page_wb_en, pge);
         if (wbe) begin
            chk(ptr_wb_val == wv && ptr_wb_sel == 2'd2, "R9", {req, " Z wb"},
                {14'd0, ptr_wb_sel, ptr_wb_val}, {16'h0002, wv});
         end
         if (pge) chk(page_wb_val == pv, "R9", {req, " page wb"}, page_wb_val, pv);
         @(negedge clk);
         chk(busy == 1'b0, "R8", {req, " busy ends"}, busy, 0);
      end
   endtask

   task automatic set_op(input logic [2:0] o, input logic [1:0] s, input bit st,
                         input bit ex, input bit im);
      op = o; ptr_sel = s; is_store = st; ext_en = ex; implicit_dst = im;
      rd_idx = 5'($urandom);
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd1357));
      repeat (3) @(negedge clk);
      chk(!busy && !data_rd && !data_wr && !prog_rd && !ptr_wb_en && !page_wb_en,
          "R1", "outputs in reset", {busy, data_rd, data_wr, prog_rd, ptr_wb_en, page_wb_en}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !ptr_wb_en, "R1", "outputs after reset", {busy, ptr_wb_en}, 0);

      // directed corners
      x_ptr = 16'hFFFF; set_op(3'd1, 2'd0, 1'b0, 1'b0, 1'b0); run_op("R3 X+ wrap", 1'b0);
      y_ptr = 16'h0000; set_op(3'd2, 2'd1, 1'b1, 1'b0, 1'b0); run_op("R4 -Y wrap", 1'b0);
      z_ptr = 16'hFFF0; disp = 6'd63; set_op(3'd3, 2'd2, 1'b0, 1'b0, 1'b0);
      run_op("R5 Z+63 wrap", 1'b0);
      set_op(3'd3, 2'd0, 1'b0, 1'b0, 1'b0); run_op("R5 disp on X", 1'b0);
      set_op(3'd0, 2'd3, 1'b0, 1'b0, 1'b0); run_op("R5 no pointer", 1'b0);
      set_op(3'd7, 2'd1, 1'b0, 1'b0, 1'b0); run_op("R5 reserved", 1'b0);
      direct_addr = 16'hBEEF; set_op(3'd4, 2'd3, 1'b1, 1'b0, 1'b0); run_op("R6 direct", 1'b0);
      y_ptr = 16'h1234; set_op(3'd0, 2'd1, 1'b0, 1'b0, 1'b0); run_op("R2 plain Y", 1'b1);
      z_ptr = 16'hFFFF; page = 8'hFF; set_op(3'd6, 2'd0, 1'b1, 1'b1, 1'b0);
      run_op("R9 ext wrap 2^24", 1'b0);
      z_ptr = 16'hFFFF; page = 8'h12; set_op(3'd6, 2'd1, 1'b0, 1'b1, 1'b1);
      run_op("R9 ext carry", 1'b0);
      z_ptr = 16'hFFFF; page = 8'h12; set_op(3'd6, 2'd2, 1'b0, 1'b0, 1'b0);
      run_op("R9 non-ext wrap", 1'b0);
      z_ptr = 16'h0042; set_op(3'd5, 2'd2, 1'b0, 1'b0, 1'b1); run_op("R10 implicit R0", 1'b1);

      for (int i = 0; i < 400; i++) begin
         x_ptr = 16'($urandom); y_ptr = 16'($urandom); z_ptr = 16'($urandom);
         page = 8'($urandom); disp = 6'($urandom); direct_addr = 16'($urandom);
         if (i % 7 == 0) x_ptr = 16'hFFFF;
         if (i % 11 == 0) y_ptr = 16'h0000;
         set_op(3'($urandom), 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
         run_op("R2 random", 1'($urandom_range(0, 3) == 0));
      end

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule